// File: doc/BRIEF.md
# I2C Master Start-Condition Controller

This block decides when an I2C master may put a start condition on the bus and then forms it on open-drain SCL and SDA. Software raises a one-cycle start request. The block looks at the bus state, which it derives from synchronized copies of SCL and SDA, and at its own role as master. From these it chooses one of four outcomes: it issues the start at once, it performs a repeated start out of a master wait, it holds the request until the bus is free, or it refuses the request.

When another master holds the bus, a mode input selects what happens to the request. Either the request is parked and its start fires on its own once a stop has been seen and the bus has stayed idle for a set time, or the request is dropped and a sticky refusal flag is raised. Several events withdraw a pending request and release both lines: arbitration loss, a stop request, a release-from-communication strobe, and disabling the controller.

The byte shifter that runs the transfer tells the block when the master sits in the post-ninth-clock wait, and whether the master is receiving with acknowledge disabled after the final byte. A request is honoured while the master owns the bus only under those conditions.

Top module: `i2c_start_ctl`

## Requirements
- R1: A request on an idle bus pulls SDA low (sda_drv=1) on the clock after the request while SCL stays released. After exactly HOLD_CYC cycles SCL is also pulled low. start_pend is 1 from the request until SCL is pulled, then 0. Both lines stay driven (wait state) until a rel_wait strobe, after which both are released on the next cycle.
- R2: A request while another master holds the bus, with rsv_dis=0, keeps start_pend at 1 and drives neither line. After the other master's stop, the start begins between FREE_CYC and FREE_CYC+6 cycles later and then proceeds as in R1.
- R3: A request while another master holds the bus, with rsv_dis=1, leaves start_pend at 0, drives neither line, and sets start_refused on the next cycle.
- R4: start_refused stays 1, including across later bus traffic, until a refuse_clr strobe clears it on the next cycle.
- R5: A request accepted in the master wait state makes a repeated start. First SDA is released with SCL held. Then both are released. Then SDA is pulled low with SCL released for HOLD_CYC cycles. Then both are pulled low and start_pend returns to 0.
- R6: A start request in the same cycle as stop_req is ignored (start_pend stays 0, no drive). A second request while one is pending is ignored (it cannot raise start_refused).
- R7: arb_lost, stop_req, rel_comm and ctrl_en=0 each clear start_pend and release both lines on the next cycle.
- R8: While the block owns the bus as master, a request outside the post-ninth-clock wait (shift_wait=0) is ignored. With shift_wait=1 and is_rx=0 it is accepted.
- R9: As master receiver (is_rx=1) with shift_wait=1, a request is accepted only when ack_en=0 and last_rx=1. Otherwise it is ignored.
- R10: After reset, scl_drv, sda_drv, start_pend and start_refused are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low aborts and clears state |
| start_req | input | 1 | Start request strobe |
| stop_req | input | 1 | Stop request strobe |
| rsv_dis | input | 1 | 1 = refuse requests on a busy bus, 0 = reserve them |
| rel_comm | input | 1 | Release-from-communication strobe |
| arb_lost | input | 1 | Arbitration lost indication |
| shift_wait | input | 1 | Byte shifter is in the wait after the ninth clock |
| is_rx | input | 1 | Master is receiving |
| ack_en | input | 1 | Acknowledge generation enabled |
| last_rx | input | 1 | Final received byte has been signalled |
| rel_wait | input | 1 | Strobe handing the lines over after this block's start |
| refuse_clr | input | 1 | Write-one-to-clear strobe for start_refused |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_drv | output | 1 | 1 pulls SCL low |
| sda_drv | output | 1 | 1 pulls SDA low |
| start_pend | output | 1 | Start request status bit |
| start_refused | output | 1 | Sticky start-refused flag |

## Verification
A wrong bus-busy or ownership state shows up within one cycle of the next request. The block then picks the wrong path: a start driven on a bus that another master holds, a refusal on an idle bus, or a silent drop, and each of these is visible on sda_drv, start_pend or start_refused. A wrong sequencer state or hold counter shows up as the wrong drive order or the wrong phase length on scl_drv and sda_drv. Timing the pulled-SDA phase in clock cycles exposes it within HOLD_CYC cycles. A stale pending bit would be seen on start_pend one cycle after any clearing event.

// File: rtl/i2c_start_ctl_pkg.sv
package i2c_start_ctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RSV    = 3'd1,
      ST_SDALO  = 3'd2,
      ST_HELD   = 3'd3,
      ST_RS_SDA = 3'd4,
      ST_RS_SCL = 3'd5
   } stc_state_t;

   function automatic int stc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/stc_sync.sv
module stc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/stc_bus_mon.sv
module stc_bus_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic start_det,
   output logic stop_det,
   output logic busy
);
   logic [1:0] lines_s;
   logic       sda_s;
   logic       scl_p;
   logic       sda_p;

   stc_sync #(.STAGES(SYNC_STAGES), .W(2)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (lines_s)
   );

   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   // SDA edge while SCL stays high on both samples
   assign start_det = scl_s && scl_p && sda_p && !sda_s;
   assign stop_det  = scl_s && scl_p && !sda_p && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end
endmodule

// File: rtl/stc_timer.sv
module stc_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (ld)        cnt <= ld_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_start_ctl.sv
module i2c_start_ctl
   import i2c_start_ctl_pkg::*;
#(
   parameter int HOLD_CYC    = 8,
   parameter int FREE_CYC    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_en,
   input  logic start_req,
   input  logic stop_req,
   input  logic rsv_dis,
   input  logic rel_comm,
   input  logic arb_lost,
   input  logic shift_wait,
   input  logic is_rx,
   input  logic ack_en,
   input  logic last_rx,
   input  logic rel_wait,
   input  logic refuse_clr,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_drv,
   output logic sda_drv,
   output logic start_pend,
   output logic start_refused
);
   localparam int CNT_W = $clog2(stc_max(HOLD_CYC, FREE_CYC) + 1);
   localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] FREE_LD = CNT_W'(FREE_CYC - 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (FREE_CYC < 1) begin : g_bad_free
         $error("FREE_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   stc_state_t       st, st_nxt;
   logic             scl_s, start_det, stop_det, busy;
   logic             tmr_ld, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             own_bus;
   logic             abort, cand, mst_ok;
   logic             acc_idle, acc_rsv, acc_rs, refuse;
   logic             start_done;

   stc_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_s     (scl_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .busy      (busy)
   );

   stc_timer #(.W(CNT_W)) i_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (tmr_ld),
      .ld_val (tmr_val),
      .zero   (tmr_zero)
   );

   // request qualification
   assign abort  = !ctrl_en || arb_lost || rel_comm || stop_req;
   assign cand   = start_req && !abort && !start_pend;
   assign mst_ok = (shift_wait || st == ST_HELD) &&
                   (!is_rx || (!ack_en && last_rx));

   assign acc_rs   = cand && own_bus && mst_ok &&
                     (st == ST_IDLE || st == ST_HELD);
   assign acc_idle = cand && !own_bus && !busy && st == ST_IDLE;
   assign acc_rsv  = cand && !own_bus && busy && !rsv_dis && st == ST_IDLE;
   assign refuse   = cand && !own_bus && busy && rsv_dis && st == ST_IDLE;

   // sequencer
   always_comb begin
      st_nxt  = st;
      tmr_ld  = 1'b0;
      tmr_val = HOLD_LD;
      unique case (st)
         ST_IDLE: begin
            if (acc_rs) begin
               st_nxt = ST_RS_SDA;
               tmr_ld = 1'b1;
            end else if (acc_idle) begin
               st_nxt = ST_SDALO;
               tmr_ld = 1'b1;
            end else if (acc_rsv) begin
               st_nxt  = ST_RSV;
               tmr_ld  = 1'b1;
               tmr_val = FREE_LD;
            end
         end
         ST_RSV: begin
            if (busy) begin
               tmr_ld  = 1'b1;
               tmr_val = FREE_LD;
            end else if (tmr_zero) begin
               st_nxt = ST_SDALO;
               tmr_ld = 1'b1;
            end
         end
         ST_SDALO: begin
            if (tmr_zero) st_nxt = ST_HELD;
         end
         ST_HELD: begin
            if (acc_rs) begin
               st_nxt = ST_RS_SDA;
               tmr_ld = 1'b1;
            end else if (rel_wait) begin
               st_nxt = ST_IDLE;
            end
         end
         ST_RS_SDA: begin
            if (tmr_zero) begin
               st_nxt = ST_RS_SCL;
               tmr_ld = 1'b1;
            end
         end
         ST_RS_SCL: begin
            if (!scl_s) begin
               tmr_ld = 1'b1;
            end else if (tmr_zero) begin
               st_nxt = ST_SDALO;
               tmr_ld = 1'b1;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
      if (abort) st_nxt = ST_IDLE;
   end

   assign start_done = (st == ST_SDALO) && (st_nxt == ST_HELD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  start_pend <= 1'b0;
      else if (abort || start_done)                start_pend <= 1'b0;
      else if (acc_idle || acc_rsv || acc_rs)      start_pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  own_bus <= 1'b0;
      else if (!ctrl_en || arb_lost || rel_comm)   own_bus <= 1'b0;
      else if (start_done)                         own_bus <= 1'b1;
      else if (stop_det)                           own_bus <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        start_refused <= 1'b0;
      else if (refuse)                   start_refused <= 1'b1;
      else if (refuse_clr || !ctrl_en)   start_refused <= 1'b0;
   end

   // line drive decode
   always_comb begin
      scl_drv = 1'b0;
      sda_drv = 1'b0;
      unique case (st)
         ST_SDALO:  sda_drv = 1'b1;
         ST_HELD:   begin scl_drv = 1'b1; sda_drv = 1'b1; end
         ST_RS_SDA: scl_drv = 1'b1;
         default:   ;
      endcase
   end
endmodule

// File: rtl/stc_start_ctl_chk.sv
module stc_start_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic ctrl_en,
   input logic start_req,
   input logic stop_req,
   input logic arb_lost,
   input logic rel_comm,
   input logic refuse_clr,
   input logic scl_drv,
   input logic sda_drv,
   input logic start_pend,
   input logic start_refused
);
   AST_SDA_FALLS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drv) |-> !scl_drv); // R1
   AST_SDA_LEADS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_drv) && sda_drv) |-> $past(sda_drv)); // R1
   AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_refused) |-> (!start_pend && !sda_drv && !scl_drv)); // R3
   AST_REFUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_refused && !refuse_clr && ctrl_en) |=> start_refused); // R4
   AST_START_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && stop_req) |=> !start_pend); // R6
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost || rel_comm || stop_req) |=> (!start_pend && !sda_drv && !scl_drv)); // R7
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> (!start_pend && !sda_drv && !scl_drv && !start_refused)); // R7
endmodule

bind i2c_start_ctl stc_start_ctl_chk i_chk (.*);

// File: tb/test_i2c_start_ctl.sv
module test_i2c_start_ctl;
   localparam int HOLD = 8;
   localparam int FREE = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_en = 1'b0, start_req = 1'b0, stop_req = 1'b0, rsv_dis = 1'b0;
   logic rel_comm = 1'b0, arb_lost = 1'b0, shift_wait = 1'b0, is_rx = 1'b0;
   logic ack_en = 1'b0, last_rx = 1'b0, rel_wait = 1'b0, refuse_clr = 1'b0;
   logic tb_scl = 1'b1, tb_sda = 1'b1;
   logic scl_in, sda_in, scl_drv, sda_drv, start_pend, start_refused;
   int   n_chk = 0;
   int   n_fail = 0;

   always #10 clk = ~clk;

   assign scl_in = tb_scl & ~scl_drv;
   assign sda_in = tb_sda & ~sda_drv;

   i2c_start_ctl #(.HOLD_CYC(HOLD), .FREE_CYC(FREE)) i_i2c_start_ctl (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .start_req(start_req),
      .stop_req(stop_req), .rsv_dis(rsv_dis), .rel_comm(rel_comm),
      .arb_lost(arb_lost), .shift_wait(shift_wait), .is_rx(is_rx),
      .ack_en(ack_en), .last_rx(last_rx), .rel_wait(rel_wait),
      .refuse_clr(refuse_clr), .scl_in(scl_in), .sda_in(sda_in),
      .scl_drv(scl_drv), .sda_drv(sda_drv), .start_pend(start_pend),
      .start_refused(start_refused)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_req();
      start_req = 1'b1; cyc(1); start_req = 1'b0;
   endtask

   task automatic other_start();
      tb_sda = 1'b0; cyc(3); tb_scl = 1'b0; cyc(6);
   endtask

   task automatic other_stop();
      tb_scl = 1'b0; cyc(2); tb_sda = 1'b0; cyc(2);
      tb_scl = 1'b1; cyc(2); tb_sda = 1'b1; cyc(6);
   endtask

   task automatic drv_state(output int v);
      v = {30'd0, scl_drv, sda_drv};
   endtask

   task automatic hand_back();
      rel_wait = 1'b1; cyc(1); rel_wait = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 scl_drv", scl_drv, 0);
      chk("R10 sda_drv", sda_drv, 0);
      chk("R10 start_pend", start_pend, 0);
      chk("R10 start_refused", start_refused, 0);
   endtask

   task automatic t_idle_start();
      int n = 0;
      pulse_req();
      chk("R1 sda pulled first", sda_drv, 1);
      chk("R1 scl released", scl_drv, 0);
      chk("R1 pend set", start_pend, 1);
      while (sda_drv && !scl_drv && n < 100) begin n++; cyc(1); end
      chk("R1 hold cycles", n, HOLD);
      chk("R1 scl pulled", scl_drv, 1);
      chk("R1 pend cleared", start_pend, 0);
      cyc(5);
      chk("R1 wait held", {scl_drv, sda_drv}, 3);
      hand_back();
      chk("R1 released after rel_wait", {scl_drv, sda_drv}, 0);
      other_stop();
   endtask

   task automatic t_same_stop();
      start_req = 1'b1; stop_req = 1'b1; cyc(1);
      start_req = 1'b0; stop_req = 1'b0;
      chk("R6 start with stop pend", start_pend, 0);
      cyc(3);
      chk("R6 start with stop drive", sda_drv, 0);
   endtask

   task automatic t_reserve();
      int n = 0;
      other_start();
      pulse_req();
      chk("R2 reserved pend", start_pend, 1);
      chk("R2 reserved no drive", {scl_drv, sda_drv}, 0);
      rsv_dis = 1'b1;
      pulse_req();
      chk("R6 second request no refuse", start_refused, 0);
      chk("R6 second request pend kept", start_pend, 1);
      rsv_dis = 1'b0;
      cyc(20);
      chk("R2 still waiting", {start_pend, sda_drv}, 2);
      tb_scl = 1'b1; cyc(2); tb_sda = 1'b1;
      while (!sda_drv && n < 200) begin n++; cyc(1); end
      chk("R2 free time lower bound", (n >= FREE) ? 1 : 0, 1);
      chk("R2 free time upper bound", (n <= FREE + 6) ? 1 : 0, 1);
      n = 0;
      while (!scl_drv && n < 100) begin n++; cyc(1); end
      chk("R2 reserved start completes", {start_pend, scl_drv, sda_drv}, 3);
      hand_back();
      other_stop();
   endtask

   task automatic t_refuse();
      other_start();
      rsv_dis = 1'b1;
      pulse_req();
      chk("R3 refused flag", start_refused, 1);
      chk("R3 no pend", start_pend, 0);
      chk("R3 no drive", {scl_drv, sda_drv}, 0);
      other_stop();
      chk("R4 flag sticky", start_refused, 1);
      refuse_clr = 1'b1; cyc(1); refuse_clr = 1'b0;
      chk("R4 flag cleared", start_refused, 0);
      rsv_dis = 1'b0;
   endtask

   task automatic t_clears();
      other_start();
      pulse_req();
      stop_req = 1'b1; cyc(1); stop_req = 1'b0;
      chk("R7 stop_req clears", start_pend, 0);
      pulse_req();
      arb_lost = 1'b1; cyc(1); arb_lost = 1'b0;
      chk("R7 arb_lost clears", start_pend, 0);
      pulse_req();
      rel_comm = 1'b1; cyc(1); rel_comm = 1'b0;
      chk("R7 rel_comm clears", start_pend, 0);
      pulse_req();
      ctrl_en = 1'b0; cyc(1); ctrl_en = 1'b1;
      chk("R7 disable clears", start_pend, 0);
      other_stop();
      pulse_req();
      cyc(2);
      arb_lost = 1'b1; cyc(1); arb_lost = 1'b0;
      chk("R7 abort releases lines", {start_pend, scl_drv, sda_drv}, 0);
      other_stop();
   endtask

   task automatic finish_restart(input string tag);
      int n = 0;
      int v;
      while (scl_drv && n < 100) begin n++; cyc(1); end
      drv_state(v);
      chk({tag, " both released"}, v, 0);
      n = 0;
      while (!sda_drv && n < 100) begin n++; cyc(1); end
      drv_state(v);
      chk({tag, " sda low scl free"}, v, 1);
      n = 0;
      while (sda_drv && !scl_drv && n < 100) begin n++; cyc(1); end
      chk({tag, " restart hold"}, n, HOLD);
      chk({tag, " restart done"}, {start_pend, scl_drv, sda_drv}, 3);
   endtask

   task automatic t_master_roles();
      int n = 0;
      pulse_req();
      while (!scl_drv && n < 100) begin n++; cyc(1); end
      hand_back();
      is_rx = 1'b1; ack_en = 1'b1; last_rx = 1'b1;
      pulse_req();
      chk("R9 rx outside wait ignored", start_pend, 0);
      shift_wait = 1'b1;
      pulse_req();
      chk("R9 ack enabled ignored", start_pend, 0);
      ack_en = 1'b0; last_rx = 1'b0;
      pulse_req();
      chk("R9 not last ignored", start_pend, 0);
      last_rx = 1'b1;
      pulse_req();
      chk("R9 accepted pend", start_pend, 1);
      chk("R5 sda released scl held", {scl_drv, sda_drv}, 2);
      finish_restart("R5");
      hand_back();
      is_rx = 1'b0; shift_wait = 1'b0;
      pulse_req();
      chk("R8 outside wait ignored", {start_pend, scl_drv, sda_drv}, 0);
      shift_wait = 1'b1;
      pulse_req();
      chk("R8 accepted in wait", start_pend, 1);
      finish_restart("R8");
      shift_wait = 1'b0;
      pulse_req();
      chk("R5 restart from held state", {start_pend, scl_drv, sda_drv}, 6);
      finish_restart("R5 held");
      hand_back();
      other_stop();
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1; ctrl_en = 1'b1;
      cyc(4);
      t_idle_start();
      t_same_stop();
      t_reserve();
      t_refuse();
      t_clears();
      t_master_roles();
      summary();
      $finish;
   end
endmodule